// File: doc/BRIEF.md
# Coprocessor Sequential Multiplier

This unit sits on a CPU's coprocessor port and executes the four integer multiply instructions: the low half of the product, and the high half with both operands signed, with a signed first operand and an unsigned second, or with both unsigned. The host asserts a valid strobe and holds it. With the strobe it presents the full 32-bit instruction word and the values of the two source registers. The unit decodes the word in the same cycle. If the word is one of its own, it raises `wait_o` at once and computes the product with a shift-and-add engine that consumes `BPS` multiplier bits per clock.

When the product is final, the unit pulses `ready_o` and `wr_o` for one cycle, with the result on `rd_o`, and the host writes it to the destination register. The unit never claims a word it does not implement, so the host's own timeout can flag such a word as illegal. A low-half multiply stops after `XLEN/BPS` steps, because the upper product bits are not needed. The high-half forms run over the full `2*XLEN/BPS` steps on operands sign- or zero-extended to double width. If the host drops valid before the result arrives, the operation is dropped without a result.

Top module: `mulco_unit`

## Requirements
- R1: The unit claims an instruction only when bits [6:0] equal 0110011, bits [31:25] equal 0000001 and bit 14 is 0. For any other word, wait_o, ready_o and wr_o stay low however long valid_i is held.
- R2: wait_o rises in the same cycle as valid_i with a claimed word. It stays high until the cycle before ready_o, and it is low whenever ready_o is high or valid_i is low.
- R3: With bits [14:12] = 000, rd_o carries the low XLEN bits of the product of rs1_i and rs2_i.
- R4: With bits [14:12] = 001, rd_o carries the high XLEN bits of the product, with both operands treated as two's-complement signed.
- R5: With bits [14:12] = 010, rd_o carries the high XLEN bits of the product of signed rs1_i and unsigned rs2_i.
- R6: With bits [14:12] = 011, rd_o carries the high XLEN bits of the unsigned product.
- R7: Counting the clock edge that samples the claim as edge 0, ready_o is high after edge XLEN/BPS for the low-half multiply and after edge 2*XLEN/BPS for the three high-half forms.
- R8: ready_o and wr_o rise together for exactly one cycle, and rd_o is zero in every cycle in which ready_o is low.
- R9: If valid_i falls before ready_o, no ready_o follows, and the next claimed word is computed correctly.
- R10: After reset, wait_o and ready_o are low. If valid_i stays high after ready_o, the unit neither claims nor completes again until valid_i has been low for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Host offers an instruction, held until ready_o or abandonment |
| insn_i | input | 32 | Instruction word under offer |
| rs1_i | input | XLEN | Value of the first source register |
| rs2_i | input | XLEN | Value of the second source register |
| wait_o | output | 1 | Unit has claimed the word and is computing |
| ready_o | output | 1 | One-cycle completion pulse |
| wr_o | output | 1 | Destination write request, pulses with ready_o |
| rd_o | output | XLEN | Result, valid while ready_o is high |

## Verification
If the step counter is corrupted or loaded with the wrong limit, ready_o arrives early or late. A run that stops early also returns an incomplete partial sum. Both show on the first instruction of the affected form, within 2*XLEN/BPS + 1 cycles of the claim.

If the wrong operand extension is latched, only the signed high-half results are affected, and only for operands with the top bit set. The sweep covers every operand pair of a 4-bit configuration, so every such pair is checked. A stuck state machine shows as wait_o without valid_i, as a second ready_o, or as a missing claim on the next instruction.

// File: rtl/mulco_pkg.sv
`timescale 1ns/1ps
package mulco_pkg;

  typedef enum logic [1:0] {
    OP_MUL    = 2'd0,
    OP_MULH   = 2'd1,
    OP_MULHSU = 2'd2,
    OP_MULHU  = 2'd3
  } mul_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_FIN,
    ST_DRAIN
  } mul_st_e;

  typedef struct packed {
    logic    hit;
    mul_op_e op;
  } mul_dec_t;

  localparam logic [6:0] OPC_REG_REG = 7'b0110011;
  localparam logic [6:0] F7_MULDIV   = 7'b0000001;

  // R1: opcode, funct7 and funct3[2] must all match
  function automatic mul_dec_t decode_word(input logic [31:0] w);
    mul_dec_t d;
    d.hit = (w[6:0] == OPC_REG_REG) && (w[31:25] == F7_MULDIV) && !w[14];
    d.op  = mul_op_e'(w[13:12]);
    return d;
  endfunction

  function automatic logic first_is_signed(input mul_op_e op);
    return (op == OP_MULH) || (op == OP_MULHSU);
  endfunction

  function automatic logic second_is_signed(input mul_op_e op);
    return op == OP_MULH;
  endfunction

  function automatic logic wants_low_half(input mul_op_e op);
    return op == OP_MUL;
  endfunction

endpackage

// File: rtl/mulco_decode.sv
`timescale 1ns/1ps
module mulco_decode
  import mulco_pkg::*;
(
  input  logic [31:0] insn_i,
  output logic        hit_o,
  output mul_op_e     op_o
);
  mul_dec_t dec;

  always_comb begin
    dec   = decode_word(insn_i);
    hit_o = dec.hit;
    op_o  = dec.op;
  end
endmodule

// File: rtl/mulco_ctrl.sv
`timescale 1ns/1ps
module mulco_ctrl
  import mulco_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int BPS  = 1
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    valid_i,
  input  logic    hit_i,
  input  mul_op_e op_i,
  output logic    claim_o,
  output logic    step_o,
  output logic    wait_o,
  output logic    ready_o,
  output mul_op_e op_q_o
);
  localparam int STEPS_LO = XLEN / BPS;
  localparam int STEPS_HI = 2 * XLEN / BPS;
  localparam int CW       = $clog2(STEPS_HI + 1);

  mul_st_e        st_q;
  logic [CW-1:0]  cnt_q;
  mul_op_e        op_q;

  assign claim_o = (st_q == ST_IDLE) && valid_i && hit_i;
  assign step_o  = (st_q == ST_RUN) && valid_i;
  assign wait_o  = valid_i && (((st_q == ST_IDLE) && hit_i) || (st_q == ST_RUN));
  assign ready_o = (st_q == ST_FIN);
  assign op_q_o  = op_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      op_q  <= OP_MUL;
    end else begin
      unique case (st_q)
        ST_IDLE: if (claim_o) begin
          st_q  <= ST_RUN;
          op_q  <= op_i;
          cnt_q <= wants_low_half(op_i) ? CW'(STEPS_LO) : CW'(STEPS_HI);
        end
        ST_RUN: begin
          if (!valid_i) begin
            st_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CW'(1)) st_q <= ST_FIN;
          end
        end
        ST_FIN:   st_q <= valid_i ? ST_DRAIN : ST_IDLE;
        ST_DRAIN: if (!valid_i) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mulco_datapath.sv
`timescale 1ns/1ps
module mulco_datapath
  import mulco_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int BPS  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic            step_i,
  input  mul_op_e         op_i,
  input  mul_op_e         op_q_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic [XLEN-1:0] result_o
);
  localparam int W2 = 2 * XLEN;

  logic [W2-1:0] mcand_q, mplier_q, acc_q;

  function automatic logic [W2-1:0] widen(input logic [XLEN-1:0] v, input logic sgn);
    return {{XLEN{sgn & v[XLEN-1]}}, v};
  endfunction

  // one engine step: add shifted multiplicand for each of BPS multiplier bits
  function automatic logic [W2-1:0] add_step(input logic [W2-1:0] acc,
                                             input logic [W2-1:0] mc,
                                             input logic [W2-1:0] mp);
    logic [W2-1:0] s;
    s = acc;
    for (int i = 0; i < BPS; i++) begin
      if (mp[i]) s = s + (mc << i);
    end
    return s;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q  <= '0;
      mplier_q <= '0;
      acc_q    <= '0;
    end else if (load_i) begin
      mcand_q  <= widen(rs1_i, first_is_signed(op_i));
      mplier_q <= widen(rs2_i, second_is_signed(op_i));
      acc_q    <= '0;
    end else if (step_i) begin
      acc_q    <= add_step(acc_q, mcand_q, mplier_q);
      mcand_q  <= mcand_q << BPS;
      mplier_q <= mplier_q >> BPS;
    end
  end

  assign result_o = wants_low_half(op_q_i) ? acc_q[XLEN-1:0] : acc_q[W2-1:XLEN];
endmodule

// File: rtl/mulco_unit.sv
`timescale 1ns/1ps
module mulco_unit
  import mulco_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int BPS  = 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            valid_i,
  input  logic [31:0]     insn_i,
  input  logic [XLEN-1:0] rs1_i,
  input  logic [XLEN-1:0] rs2_i,
  output logic            wait_o,
  output logic            ready_o,
  output logic            wr_o,
  output logic [XLEN-1:0] rd_o
);
  logic            hit_w;
  mul_op_e         op_w;
  logic            claim_w;
  logic            step_w;
  mul_op_e         op_q_w;
  logic [XLEN-1:0] result_w;

  mulco_decode u_dec (
    .insn_i (insn_i),
    .hit_o  (hit_w),
    .op_o   (op_w)
  );

  mulco_ctrl #(.XLEN(XLEN), .BPS(BPS)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .hit_i   (hit_w),
    .op_i    (op_w),
    .claim_o (claim_w),
    .step_o  (step_w),
    .wait_o  (wait_o),
    .ready_o (ready_o),
    .op_q_o  (op_q_w)
  );

  mulco_datapath #(.XLEN(XLEN), .BPS(BPS)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (claim_w),
    .step_i   (step_w),
    .op_i     (op_w),
    .op_q_i   (op_q_w),
    .rs1_i    (rs1_i),
    .rs2_i    (rs2_i),
    .result_o (result_w)
  );

  assign wr_o = ready_o;
  assign rd_o = ready_o ? result_w : '0;
endmodule

// File: rtl/mulco_checker.sv
`timescale 1ns/1ps
module mulco_checker
  import mulco_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int BPS  = 1
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic [31:0]     insn_i,
  input logic            wait_o,
  input logic            ready_o,
  input logic            wr_o,
  input logic [XLEN-1:0] rd_o,
  input logic            claim_w,
  input mul_op_e         op_q_w
);
  localparam int STEPS_LO = XLEN / BPS;
  localparam int STEPS_HI = 2 * XLEN / BPS;
  localparam int CW       = $clog2(STEPS_HI + 2);

  logic          own_word;
  logic          on_q;
  logic [CW-1:0] lat_q;

  assign own_word = (insn_i[6:0] == 7'h33) && (insn_i[31:25] == 7'h01) && (insn_i[14] == 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      lat_q <= '0;
    end else if (claim_w) begin
      on_q  <= 1'b1;
      lat_q <= '0;
    end else if (on_q) begin
      lat_q <= lat_q + 1'b1;
      if (ready_o) on_q <= 1'b0;
    end
  end

  AST_FOREIGN_NOT_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    !own_word |-> !claim_w); // R1
  AST_WAIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wait_o |-> valid_i); // R2
  AST_WAIT_NOT_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wait_o && ready_o)); // R2
  AST_READY_FOLLOWS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> $past(wait_o)); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (on_q && (lat_q == ((op_q_w == OP_MUL) ? CW'(STEPS_LO) : CW'(STEPS_HI))))); // R7
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |=> !ready_o); // R8
  AST_WR_MATCHES_READY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_o == ready_o); // R8
  AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> (rd_o == '0)); // R8
  AST_ABANDON_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !ready_o) |=> !ready_o); // R9
endmodule

bind mulco_unit mulco_checker #(.XLEN(XLEN), .BPS(BPS)) u_mulco_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid_i (valid_i),
  .insn_i  (insn_i),
  .wait_o  (wait_o),
  .ready_o (ready_o),
  .wr_o    (wr_o),
  .rd_o    (rd_o),
  .claim_w (claim_w),
  .op_q_w  (op_q_w)
);

// File: tb/mulco_unit_bench.sv
`timescale 1ns/1ps
module mulco_unit_bench;
  localparam int XLEN = 4;
  localparam int BPS  = 1;
  localparam int MASK = (1 << XLEN) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            valid_i = 1'b0;
  logic [31:0]     insn_i = '0;
  logic [XLEN-1:0] rs1_i = '0;
  logic [XLEN-1:0] rs2_i = '0;
  logic            wait_o, ready_o, wr_o;
  logic [XLEN-1:0] rd_o;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mulco_unit #(.XLEN(XLEN), .BPS(BPS)) u_mulco_unit (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .insn_i(insn_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .wait_o(wait_o), .ready_o(ready_o),
    .wr_o(wr_o), .rd_o(rd_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] mk_word(input int f3);
    return {7'b0000001, 5'd2, 5'd1, 3'(f3), 5'd3, 7'b0110011};
  endfunction

  function automatic int as_signed(input int v);
    return (v >= (1 << (XLEN - 1))) ? v - (1 << XLEN) : v;
  endfunction

  function automatic int model(input int f3, input int a, input int b);
    int sa, sb, p;
    sa = (f3 == 1 || f3 == 2) ? as_signed(a) : a;
    sb = (f3 == 1) ? as_signed(b) : b;
    p  = sa * sb;
    return (f3 == 0) ? (p & MASK) : ((p >>> XLEN) & MASK);
  endfunction

  // issue one claimed op; returns with valid still high at the negedge where ready was seen
  task automatic issue(input int f3, input int a, input int b, output bit got, output int n);
    bit wait_ok;
    @(negedge clk);
    insn_i = mk_word(f3); rs1_i = XLEN'(a); rs2_i = XLEN'(b); valid_i = 1'b1;
    #1;
    chk(wait_o === 1'b1, "R2 wait same cycle", int'(wait_o), 1);
    wait_ok = 1'b1; got = 1'b0; n = 0;
    while (!got && n < 40) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (ready_o) got = 1'b1;
      else if (wait_o !== 1'b1) wait_ok = 1'b0;
    end
    chk(wait_ok, "R2 wait held", int'(wait_ok), 1);
    chk(got && wait_o === 1'b0, "R2 wait low at ready", int'(wait_o), 0);
  endtask

  task automatic run_op(input int f3, input int a, input int b);
    bit got; int n; int exp_n; string rq;
    issue(f3, a, b, got, n);
    exp_n = ((f3 == 0) ? XLEN / BPS : 2 * XLEN / BPS) + 1;
    chk(got && n == exp_n, "R7 latency", n, exp_n);
    rq = (f3 == 0) ? "R3 low product" : (f3 == 1) ? "R4 signed high" :
         (f3 == 2) ? "R5 mixed high" : "R6 unsigned high";
    chk(got && int'(rd_o) == model(f3, a, b), rq, int'(rd_o), model(f3, a, b));
    chk(wr_o === 1'b1, "R8 wr with ready", int'(wr_o), 1);
    valid_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(ready_o === 1'b0 && wr_o === 1'b0 && rd_o == '0, "R8 single pulse", int'(ready_o), 0);
  endtask

  task automatic foreign(input logic [31:0] w);
    bit quiet = 1'b1;
    @(negedge clk);
    insn_i = w; valid_i = 1'b1;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (wait_o || ready_o || wr_o) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet, "R1 foreign word ignored", int'(quiet), 1);
    valid_i = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(wait_o === 1'b0 && ready_o === 1'b0, "R10 reset state", int'(wait_o | ready_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wait_o === 1'b0 && ready_o === 1'b0, "R10 idle after reset", int'(wait_o | ready_o), 0);

    // R1: foreign words
    foreign({7'b0000001, 5'd2, 5'd1, 3'b100, 5'd3, 7'b0110011});
    foreign({7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011});
    foreign({7'b0100000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011});
    foreign({7'b0000001, 5'd2, 5'd1, 3'b001, 5'd3, 7'b0010011});

    // R3..R6, R7, R8: exhaustive sweep
    for (int f = 0; f < 4; f++)
      for (int a = 0; a <= MASK; a++)
        for (int b = 0; b <= MASK; b++)
          run_op(f, a, b);

    // R9: abandon mid-run
    @(negedge clk);
    insn_i = mk_word(3); rs1_i = XLEN'(15); rs2_i = XLEN'(15); valid_i = 1'b1;
    repeat (3) @(negedge clk);
    valid_i = 1'b0;
    begin
      bit silent = 1'b1;
      for (int i = 0; i < 15; i++) begin
        @(negedge clk);
        if (ready_o || wait_o) silent = 1'b0;
      end
      chk(silent, "R9 no result after abandon", int'(silent), 1);
    end
    run_op(0, 7, 6);
    run_op(1, 9, 13);

    // R10: valid held past ready
    begin
      bit got; int n; bit quiet = 1'b1;
      issue(2, 12, 5, got, n);
      chk(got && int'(rd_o) == model(2, 12, 5), "R10 result before hold", int'(rd_o), model(2, 12, 5));
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (wait_o || ready_o) quiet = 1'b0;
      end
      chk(quiet, "R10 no reclaim while valid held", int'(quiet), 1);
      valid_i = 1'b0;
      @(negedge clk);
    end
    run_op(3, 11, 14);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule